// File: doc/BRIEF.md
# Serial Flash Bitstream Loader

This block reads a configuration bitstream out of serial NOR flash after power-up. It drives the flash clock, chip select and command line itself. It can read one single-bit device, or four single-bit devices side by side that together deliver a nibble per flash clock. A start pulse begins a load. The loader sends a read command with a fixed start address and then receives data. Each assembled byte appears on a byte stream with a one-cycle valid strobe. After the programmed number of bytes, the loader releases chip select and raises done.

Every load begins with the flash clock at one eighth of the system clock, which suits any flash part. Early in the stream, the bitstream may carry a rate-select command: a marker byte followed by an argument byte. The loader recognises it in flight and switches to the chosen divider (1, 2, 4 or 8) at the next byte boundary without a clock glitch. The command bytes are still passed downstream. The block does not interpret any other content of the stream.

Top module: `sfl_loader`

## Requirements
- R1: During and after reset, cs_n_o is 1, sck_o is 0, done_o is 0 and byte_vld_o is 0.
- R2: An accepted start drives cs_n_o low and shifts 32 bits out on mosi_o, most significant bit first: opcode 0x03, then a 24-bit address of zero. Each bit is stable at the rising edge of sck_o.
- R3: Divide codes select the flash clock: 0 selects /1, 1 selects /2, 2 selects /4 and 3 selects /8. One flash bit lasts 2^code system cycles. sck_o is low in the first half of each bit and high in the second half. For /1 it is high while the system clock is low.
- R4: Each load begins with divide code 3 (/8). The first byte is therefore valid exactly 256 + 8*C system cycles after the start edge, where C is the number of flash clocks per byte (R5, R6).
- R5: In single mode (quad_i = 0 at start), each byte is taken from miso_i[0], eight bits most significant first. C = 8.
- R6: In quad mode (quad_i = 1 at start), device k drives bit k of each nibble, and the high nibble arrives first. C = 2. The mode is latched at start.
- R7: A data byte 0xD1 followed by an argument byte sets the divide code to the argument's bits [1:0]. The new code applies from the first bit after the argument byte. The argument's upper bits are ignored. Both bytes are still output.
- R8: A 0xD1 counts as a rate command only if its byte index (0 = first data byte) is below WINDOW (default 16). A later 0xD1 is ordinary data and leaves the rate unchanged.
- R9: After byte_count_i bytes, cs_n_o goes high, sck_o stays low and done_o stays high until the next start. A count of zero ends the load right after the command.
- R10: A start pulse while a load is in progress is ignored. The running load completes with its own count and timing.
- R11: Each byte is presented on byte_o with byte_vld_o high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a load when idle or done |
| quad_i | input | 1 | Selects four-device mode, sampled at start |
| byte_count_i | input | CNT_W | Number of bytes to read, sampled at start |
| done_o | output | 1 | High once the load has finished |
| sck_o | output | 1 | Flash clock |
| cs_n_o | output | 1 | Flash chip select, active low |
| mosi_o | output | 1 | Command and address to the flash device(s) |
| miso_i | input | LANES | Data from the flash device(s) |
| byte_o | output | 8 | Assembled stream byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |

## Verification
The assertions assume three things about the inputs. start_i is a single-cycle pulse. byte_count_i and quad_i are stable when start is sampled. The flash changes miso_i only after a falling edge of sck_o, so that each bit stays constant while the loader samples it at the end of its bit period. The bench flash model updates its lines one nanosecond after each falling clock edge and holds the start inputs constant around the pulse. A second start pulse arrives only inside a running data phase, so that R10 is exercised without violating these assumptions.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;

   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_CMD  = 2'd1,
      LD_DATA = 2'd2,
      LD_DONE = 2'd3
   } ld_state_e;

   typedef enum logic [1:0] {
      DIV_1 = 2'd0,
      DIV_2 = 2'd1,
      DIV_4 = 2'd2,
      DIV_8 = 2'd3
   } sck_div_e;

   localparam sck_div_e   DIV_SAFE      = DIV_8;
   localparam logic [7:0] RATE_CMD_BYTE = 8'hD1;

   // last cycle index inside one flash bit for a divide code
   function automatic logic [2:0] div_mask(input sck_div_e c);
      logic [2:0] m;
      case (c)
         DIV_1:   m = 3'd0;
         DIV_2:   m = 3'd1;
         DIV_4:   m = 3'd3;
         default: m = 3'd7;
      endcase
      return m;
   endfunction

   // first cycle index of the high half of sck
   function automatic logic [2:0] div_half(input sck_div_e c);
      return (div_mask(c) >> 1) + 3'd1;
   endfunction

endpackage

// File: rtl/sfl_sck_gen.sv
`timescale 1ns/1ps
module sfl_sck_gen
   import sfl_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     run_i,
   input  sck_div_e div_q_i,
   input  sck_div_e div_d_i,
   output logic     bit_end_o,
   output logic     sck_o
);

   logic [2:0] cnt_q;
   logic [2:0] cnt_d;
   logic [2:0] last_idx;
   logic       sck_q;
   logic       sck_d;

   assign last_idx  = div_mask(div_q_i);
   assign bit_end_o = run_i && (cnt_q == last_idx);

   always_comb begin
      if (!run_i || bit_end_o) begin
         cnt_d = 3'd0;
      end else begin
         cnt_d = cnt_q + 3'd1;
      end
   end

   // registered sck for the divided rates, computed for the next cycle's divider
   always_comb begin
      sck_d = run_i && (div_d_i != DIV_1) && (cnt_d >= div_half(div_d_i));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= 3'd0;
         sck_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         sck_q <= sck_d;
      end
   end

   // full rate: high while the system clock is low; run_i only moves when that is 0
   assign sck_o = (div_q_i == DIV_1) ? (run_i & ~clk_i) : sck_q;

   // R3
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= last_idx);

   // R7
   div_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(div_q_i) |-> cnt_q == 3'd0);

   // R9
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !sck_q);

endmodule

// File: rtl/sfl_cmd_tx.sv
`timescale 1ns/1ps
module sfl_cmd_tx #(
   parameter int               ADDR_W     = 24,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [7:0]       READ_OP    = 8'h03
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic shift_i,
   output logic mosi_o,
   output logic last_o
);

   localparam int CMD_BITS = 8 + ADDR_W;
   localparam int IDX_W    = $clog2(CMD_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_BITS - 1);

   logic [CMD_BITS-1:0] sh_q;
   logic [IDX_W-1:0]    idx_q;

   assign last_o = shift_i && (idx_q == LAST_IDX);
   assign mosi_o = sh_q[CMD_BITS-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= {READ_OP, START_ADDR};
         idx_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {sh_q[CMD_BITS-2:0], 1'b0};
         idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
      end
   end

   // R2
   mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && !load_i) |=> $stable(mosi_o));

endmodule

// File: rtl/sfl_rx_asm.sv
`timescale 1ns/1ps
module sfl_rx_asm #(
   parameter int LANES = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             quad_i,
   input  logic             take_i,
   input  logic [LANES-1:0] miso_i,
   output logic [7:0]       byte_nxt_o,
   output logic             fin_o,
   output logic [7:0]       byte_o,
   output logic             vld_o
);

   logic [7:0] sh_q;
   logic [7:0] sh_d;
   logic [2:0] pos_q;
   logic [2:0] last_pos;

   generate
      if (LANES == 4) begin : g_wide
         // device k supplies bit k of the nibble, high nibble first
         assign sh_d     = quad_i ? {sh_q[3:0], miso_i} : {sh_q[6:0], miso_i[0]};
         assign last_pos = quad_i ? 3'd1 : 3'd7;
      end else begin : g_narrow
         logic unused_quad;
         assign unused_quad = quad_i;
         assign sh_d        = {sh_q[6:0], miso_i[0]};
         assign last_pos    = 3'd7;
      end
   endgenerate

   assign fin_o      = take_i && (pos_q == last_pos);
   assign byte_nxt_o = sh_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= 8'h00;
         pos_q  <= 3'd0;
         byte_o <= 8'h00;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= fin_o;
         if (clr_i) begin
            pos_q <= 3'd0;
         end else if (take_i) begin
            sh_q  <= sh_d;
            pos_q <= fin_o ? 3'd0 : pos_q + 3'd1;
         end
         if (fin_o) begin
            byte_o <= sh_d;
         end
      end
   end

   // R11
   vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |=> !vld_o);

   // R6
   pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pos_q <= last_pos);

endmodule

// File: rtl/sfl_rate_watch.sv
`timescale 1ns/1ps
module sfl_rate_watch
   import sfl_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int WINDOW = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             fin_i,
   input  logic [7:0]       byte_i,
   input  logic [CNT_W-1:0] idx_i,
   output sck_div_e         div_q_o,
   output sck_div_e         div_d_o
);

   logic armed_q;
   logic armed_d;
   logic in_window;

   generate
      if (WINDOW < 1) begin : g_bad_window
         $error("sfl_rate_watch: WINDOW must be at least 1");
      end
   endgenerate

   assign in_window = int'(idx_i) < WINDOW;

   always_comb begin
      div_d_o = div_q_o;
      armed_d = armed_q;
      if (start_i) begin
         div_d_o = DIV_SAFE;
         armed_d = 1'b0;
      end else if (fin_i) begin
         if (armed_q) begin
            div_d_o = sck_div_e'(byte_i[1:0]);
            armed_d = 1'b0;
         end else if (byte_i == RATE_CMD_BYTE && in_window) begin
            armed_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q_o <= DIV_SAFE;
         armed_q <= 1'b0;
      end else begin
         div_q_o <= div_d_o;
         armed_q <= armed_d;
      end
   end

   // R4
   safe_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> div_q_o == DIV_SAFE);

   // R7
   div_change_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q_o != $past(div_q_o)) |-> ($past(start_i) || ($past(armed_q) && $past(fin_i))));

   // R8
   arm_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && fin_i && !start_i && !in_window) |=> !armed_q);

endmodule

// File: rtl/sfl_loader.sv
`timescale 1ns/1ps
module sfl_loader
   import sfl_pkg::*;
#(
   parameter int                LANES      = 4,
   parameter int                CNT_W      = 24,
   parameter int                ADDR_W     = 24,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [7:0]        READ_OP    = 8'h03,
   parameter int                WINDOW     = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             quad_i,
   input  logic [CNT_W-1:0] byte_count_i,
   output logic             done_o,
   output logic             sck_o,
   output logic             cs_n_o,
   output logic             mosi_o,
   input  logic [LANES-1:0] miso_i,
   output logic [7:0]       byte_o,
   output logic             byte_vld_o
);

   generate
      if (LANES != 1 && LANES != 4) begin : g_bad_lanes
         $error("sfl_loader: LANES must be 1 or 4");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
         $error("sfl_loader: CNT_W must be within 1..31");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("sfl_loader: ADDR_W must be within 1..32");
      end
   endgenerate

   ld_state_e        state_q;
   ld_state_e        state_d;
   logic             quad_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] seen_q;
   logic             cs_n_q;
   logic             done_q;

   logic             run;
   logic             start_ok;
   logic             bit_end;
   logic             cmd_shift;
   logic             cmd_last;
   logic             take;
   logic             fin;
   logic             last_byte;
   logic [7:0]       byte_nxt;
   sck_div_e         div_q;
   sck_div_e         div_d;

   assign run       = (state_q == LD_CMD) || (state_q == LD_DATA);
   assign start_ok  = start_i && ((state_q == LD_IDLE) || (state_q == LD_DONE));
   assign cmd_shift = bit_end && (state_q == LD_CMD);
   assign take      = bit_end && (state_q == LD_DATA);
   assign last_byte = fin && ((seen_q + CNT_W'(1)) == len_q);

   always_comb begin
      state_d = state_q;
      case (state_q)
         LD_IDLE, LD_DONE: begin
            if (start_i) state_d = LD_CMD;
         end
         LD_CMD: begin
            if (cmd_last) state_d = (len_q == '0) ? LD_DONE : LD_DATA;
         end
         LD_DATA: begin
            if (last_byte) state_d = LD_DONE;
         end
         default: state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LD_IDLE;
         quad_q  <= 1'b0;
         len_q   <= '0;
         seen_q  <= '0;
         cs_n_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n_q  <= !((state_d == LD_CMD) || (state_d == LD_DATA));
         done_q  <= (state_d == LD_DONE);
         if (start_ok) begin
            quad_q <= quad_i;
            len_q  <= byte_count_i;
            seen_q <= '0;
         end else if (fin) begin
            seen_q <= seen_q + CNT_W'(1);
         end
      end
   end

   assign cs_n_o = cs_n_q;
   assign done_o = done_q;

   sfl_sck_gen i_sck_gen (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .div_q_i   (div_q),
      .div_d_i   (div_d),
      .bit_end_o (bit_end),
      .sck_o     (sck_o)
   );

   sfl_cmd_tx #(
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR),
      .READ_OP    (READ_OP)
   ) i_cmd_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (start_ok),
      .shift_i (cmd_shift),
      .mosi_o  (mosi_o),
      .last_o  (cmd_last)
   );

   sfl_rx_asm #(
      .LANES (LANES)
   ) i_rx_asm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (start_ok),
      .quad_i     (quad_q),
      .take_i     (take),
      .miso_i     (miso_i),
      .byte_nxt_o (byte_nxt),
      .fin_o      (fin),
      .byte_o     (byte_o),
      .vld_o      (byte_vld_o)
   );

   sfl_rate_watch #(
      .CNT_W  (CNT_W),
      .WINDOW (WINDOW)
   ) i_rate_watch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_ok),
      .fin_i   (fin),
      .byte_i  (byte_nxt),
      .idx_i   (seen_q),
      .div_q_o (div_q),
      .div_d_o (div_d)
   );

   // R9
   done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> cs_n_o);

   // R10
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == LD_DATA) && start_i && !last_byte) |=> state_q == LD_DATA);

   // R9
   count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LD_DATA) |-> seen_q < len_q);

   // R2
   cmd_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_ok |=> !cs_n_o && !done_o);

endmodule

// File: tb/test_sfl_loader.sv
`timescale 1ns/1ps
module test_sfl_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        quad = 1'b0;
   logic [23:0] cnt = '0;
   logic [3:0]  miso = 4'h0;
   logic        done_o, sck_o, cs_n_o, mosi_o, byte_vld_o;
   logic [7:0]  byte_o;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   logic [7:0] strm [0:31];
   logic [7:0] rcv_b [0:63];
   int         rcv_t [0:63];
   int         rcv_n = 0;
   int         vld_run = 0;
   int         vld_max = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sfl_loader i_sfl_loader (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .start_i      (start),
      .quad_i       (quad),
      .byte_count_i (cnt),
      .done_o       (done_o),
      .sck_o        (sck_o),
      .cs_n_o       (cs_n_o),
      .mosi_o       (mosi_o),
      .miso_i       (miso),
      .byte_o       (byte_o),
      .byte_vld_o   (byte_vld_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // byte monitor
   always @(negedge clk) begin
      if (byte_vld_o) begin
         if (rcv_n < 64) begin
            rcv_b[rcv_n] = byte_o;
            rcv_t[rcv_n] = cyc;
         end
         rcv_n++;
         vld_run++;
         if (vld_run > vld_max) vld_max = vld_run;
      end else begin
         vld_run = 0;
      end
   end

   // flash model: samples on rising sck, drives after falling sck
   int          fl_bits = 0;
   int          fl_d = 0;
   logic [31:0] fl_cmd = '0;

   function automatic logic [3:0] fl_out(input int d, input bit q);
      logic [7:0] b;
      if (q) begin
         b = strm[(d / 2) % 32];
         return (d % 2 == 0) ? b[7:4] : b[3:0];
      end
      b = strm[(d / 8) % 32];
      return {3'b000, b[7 - (d % 8)]};
   endfunction

   always @(negedge cs_n_o) begin
      fl_bits = 0;
      fl_d    = 0;
      fl_cmd  = '0;
   end

   always @(posedge sck_o) begin
      if (!cs_n_o && fl_bits < 32) begin
         fl_cmd = {fl_cmd[30:0], mosi_o};
         fl_bits++;
         // R2: opcode 0x03 then address zero, msb first
         if (fl_bits == 32) chk(fl_cmd == 32'h0300_0000, "R2", int'(fl_cmd), 32'h0300_0000);
      end
   end

   always @(negedge sck_o) begin
      if (!cs_n_o && fl_bits >= 32) begin
         miso <= #1 fl_out(fl_d, quad);
         fl_d++;
      end
   end

   task automatic fill(input int seed, input int n);
      for (int i = 0; i < n; i++) begin
         strm[i] = 8'((i * 29) + (seed * 13) + 7);
         if (strm[i] == 8'hD1) strm[i] = 8'h11;
      end
   endtask

   task automatic run_load(input bit q, input int n, input string gtag, input bit poke);
      int  t0;
      int  dv;
      int  bad;
      bit  arm;
      bit  seen_done;
      quad  = q;
      cnt   = 24'(n);
      rcv_n = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t0 = cyc;
      seen_done = 1'b0;
      for (int c = 0; c < 20000 && !seen_done; c++) begin
         @(negedge clk);
         start = poke && (c == 300);
         if (done_o) seen_done = 1'b1;
      end
      start = 1'b0;
      chk(seen_done, "R9", int'(seen_done), 1);
      bad = 0;
      repeat (16) begin
         @(negedge clk);
         if (sck_o || !cs_n_o || !done_o) bad++;
      end
      // R9: released and quiet after the count; R10: count unaffected by a busy start
      chk(bad == 0, "R9", bad, 0);
      chk(rcv_n == n, poke ? "R10" : "R9", rcv_n, n);
      dv  = 3;
      arm = 1'b0;
      for (int k = 0; k < n && k < 64; k++) begin
         int cpb     = q ? 2 : 8;
         int exp_gap = ((k == 0) ? 256 : 0) + cpb * (1 << dv);
         int act_gap = rcv_t[k] - ((k == 0) ? t0 : rcv_t[k - 1]);
         chk(rcv_b[k] == strm[k], q ? "R6" : "R5", int'(rcv_b[k]), int'(strm[k]));
         chk(act_gap == exp_gap, (k == 0) ? "R4" : gtag, act_gap, exp_gap);
         if (arm) begin
            dv  = int'(strm[k][1:0]);
            arm = 1'b0;
         end else if (strm[k] == 8'hD1 && k < 16) begin
            arm = 1'b1;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n_o == 1'b1, "R1", int'(cs_n_o), 1);
      chk(sck_o == 1'b0, "R1", int'(sck_o), 0);
      chk(done_o == 1'b0, "R1", int'(done_o), 0);
      chk(byte_vld_o == 1'b0, "R1", int'(byte_vld_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1 && sck_o == 1'b0, "R1", int'({cs_n_o, sck_o}), 2);

      // R7 sweep of every rate code in both modes; upper argument bits set
      for (int q = 0; q < 2; q++) begin
         for (int code = 0; code < 4; code++) begin
            fill(q * 4 + code, 10);
            strm[1] = 8'hD1;
            strm[2] = 8'hF0 | 8'(code);
            run_load(q[0], 10, "R7", 1'b0);
         end
      end

      // R3 no rate command: whole load at /8
      fill(21, 6);
      run_load(1'b0, 6, "R3", 1'b0);

      // R8 window edge: index 15 accepted, index 17 ignored
      fill(9, 22);
      strm[15] = 8'hD1;
      strm[16] = 8'h01;
      strm[17] = 8'hD1;
      strm[18] = 8'h00;
      run_load(1'b1, 22, "R8", 1'b0);

      // R9 zero count
      run_load(1'b0, 0, "R9", 1'b0);

      // R10 start during data phase
      fill(3, 6);
      run_load(1'b0, 6, "R10", 1'b1);

      // R11 strobe width
      chk(vld_max == 1, "R11", vld_max, 1);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule